// File: doc/BRIEF.md
# PCI Configuration and Special-Cycle Initiator

This block turns processor register accesses into single-phase transactions on a simplified 32-bit PCI initiator. Software first loads a configuration selector register (enable, bus, device, function, register). A later access to the configuration data port becomes one of three things. It becomes a broadcast special cycle when the selector holds the one reserved all-ones device/function pattern on the local bus. It becomes a type 1 configuration cycle when the bus number is not local. Otherwise it becomes a type 0 configuration cycle. A read of the interrupt-acknowledge port starts an interrupt-acknowledge cycle.

The initiator drives FRAME, IRDY, the command and byte enables on C/BE, and AD. It then drives even parity one clock behind every phase it sources. Special cycles never wait for a target. They always end in master-abort, and that termination leaves the received-master-abort status bit untouched. Any other cycle that finds no DEVSEL within the timeout does set that bit. While a transaction is in flight the block reports busy and drops new processor requests.

Top module: `pci_cfg_issuer`

## Requirements
- R1: A write to the data port (word offset 1) starts a special cycle when the selector has enable set, bus 0x00, device 5'b11111, function 3'b111 and register 6'b000000. Its address phase shows C/BE = 4'b0001, AD = 32'h0 with AD driven.
- R2: A data-port access with enable set and a nonzero bus number starts a type 1 configuration cycle, whatever the other fields hold. The address phase shows AD = {8'h00, bus, device, function, register, 2'b01}. C/BE is 4'b1011 for a write and 4'b1010 for a read.
- R3: A data-port access with enable set, bus 0x00 and no special-cycle match starts a type 0 configuration cycle with the same commands as R2. The address phase shows AD[1:0] = 2'b00, AD[7:2] = register and AD[10:8] = function. AD[31:11] has only bit (11 + device) set when device < 21, and is all zero otherwise.
- R4: After the address phase, IRDY stays high for WAIT_STATES clocks and then goes low. From the first IRDY-low clock of a write, AD equals the written word (message in bits 15:0, optional data in bits 31:16) and C/BE = 4'b0000.
- R5: A special cycle ignores DEVSEL and TRDY. FRAME is low for ABORT_CLKS + 1 clocks. FRAME then rises while IRDY is still low, and IRDY rises one clock later.
- R6: A special cycle's master-abort leaves status bit 0 (word offset 3) unchanged. A configuration or interrupt-acknowledge cycle with no DEVSEL by the ABORT_CLKS-th clock after FRAME falls sets it, and its read returns 32'hFFFFFFFF. A DEVSEL first seen exactly on that clock still counts as a claim. Writing 1 to status bit 0 clears it.
- R7: A read of word offset 2 starts an interrupt-acknowledge cycle with C/BE = 4'b0000 and AD = 32'h0 in the address phase. A write to word offset 2 starts no bus activity.
- R8: When PAR_OE is high, PAR equals the XOR of AD and C/BE as driven one clock earlier. PAR_OE equals the previous clock's AD output enable.
- R9: While busy is high, processor requests are dropped. A selector write made then does not change the value read back from word offset 0.
- R10: With enable clear, a data-port access starts no bus cycle. It completes on the next clock, and a read returns 32'hFFFFFFFF.
- R11: A claimed read (DEVSEL, then TRDY) completes on the first clock where DEVSEL has been seen and TRDY is low. cpu_done then pulses two clocks later with cpu_rdata equal to the AD sampled on that clock. The status bit is not set.
- R12: FRAME falls only on the clock after an accepted processor request. No bus cycle starts spontaneously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_ofs | input | 2 | Word offset: 0 selector, 1 data port, 2 interrupt-acknowledge, 3 status |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | Bus transaction in flight; requests are dropped |
| cpu_done | output | 1 | One-clock completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| pci_ad_out | output | 32 | AD value driven |
| pci_ad_oe | output | 1 | AD output enable |
| pci_ad_in | input | 32 | AD value received |
| pci_cbe_n | output | 4 | Command / byte enables |
| pci_frame_n | output | 1 | FRAME, active low |
| pci_irdy_n | output | 1 | IRDY, active low |
| pci_devsel_n | input | 1 | DEVSEL from targets, active low |
| pci_trdy_n | input | 1 | TRDY from target, active low |
| pci_par | output | 1 | Even parity over AD and C/BE of the previous clock |
| pci_par_oe | output | 1 | PAR output enable |

## Verification
The master-abort timeout and a target's DEVSEL claim can land on the same clock: the ABORT_CLKS-th clock after FRAME falls. The bench provokes this on a configuration read by asserting DEVSEL and TRDY first on exactly that clock. It also runs the case where DEVSEL comes one clock later. The first case must return the target's AD value with the status bit clear. The second must return all ones with the status bit set. Both release FRAME on the same clock, so only the read data and the status readback tell them apart.

// File: rtl/pci_iss_pkg.sv
// Package: shared types and encodings for the PCI configuration / special-cycle initiator.
// Assumes a 32-bit AD bus and the classic selector field layout decoded by the bus side.
package pci_iss_pkg;

    localparam int AD_W     = 32;
    localparam int CBE_W    = 4;
    localparam int IDSEL_LO = 11;
    localparam int IDSEL_W  = AD_W - IDSEL_LO;

    localparam logic [CBE_W-1:0] CMD_IACK    = 4'b0000;
    localparam logic [CBE_W-1:0] CMD_SPECIAL = 4'b0001;
    localparam logic [CBE_W-1:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [CBE_W-1:0] CMD_CFG_WR  = 4'b1011;

    localparam logic [1:0] OFS_SEL  = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_IACK = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_DATA,
        ST_REL
    } bus_st_e;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] rg;
    } sel_t;

endpackage

// File: rtl/pci_iss_decode.sv
// Module: pci_iss_decode
// Classifies an accepted processor access into a bus transaction and forms its
// address-phase AD value and command. Purely combinational.
// Assumes the selector fields are already split out of the stored register.
module pci_iss_decode
    import pci_iss_pkg::*;
(
    input  sel_t              sel,
    input  logic [1:0]        ofs,
    input  logic              we,
    output logic              go,
    output logic              special,
    output logic              is_wr,
    output logic [CBE_W-1:0]  cmd,
    output logic [AD_W-1:0]   addr_ad
);

    logic             pattern;
    logic [IDSEL_W-1:0] idsel;
    logic [AD_W-1:0]  t0_ad;
    logic [AD_W-1:0]  t1_ad;

    // One IDSEL line per decodable device number.
    for (genvar g = 0; g < IDSEL_W; g++) begin : g_idsel
        assign idsel[g] = (sel.dev == 5'(g));
    end

    assign pattern = (sel.dev == 5'h1F) && (sel.fn == 3'h7) && (sel.rg == 6'h00);
    assign t0_ad   = {idsel, sel.fn, sel.rg, 2'b00};
    assign t1_ad   = {8'h00, sel.bus, sel.dev, sel.fn, sel.rg, 2'b01};

    // Pick transaction kind, command and address-phase value.
    always_comb begin
        go      = 1'b0;
        special = 1'b0;
        is_wr   = we;
        cmd     = CMD_IACK;
        addr_ad = '0;
        if (ofs == OFS_DATA && sel.en) begin
            go  = 1'b1;
            cmd = we ? CMD_CFG_WR : CMD_CFG_RD;
            if (sel.bus != 8'h00) begin
                addr_ad = t1_ad;
            end else if (pattern && we) begin
                special = 1'b1;
                cmd     = CMD_SPECIAL;
                addr_ad = '0;
            end else begin
                addr_ad = t0_ad;
            end
        end else if (ofs == OFS_IACK && !we) begin
            go  = 1'b1;
            cmd = CMD_IACK;
        end
    end

endmodule

// File: rtl/pci_iss_seq.sv
// Module: pci_iss_seq
// Runs one single-phase initiator transaction: address phase, wait states,
// data phase, then FRAME release followed by IRDY release one clock later.
// Special cycles ignore the target and always end by timeout (master-abort).
// Assumes no target holds DEVSEL without eventually giving TRDY.
module pci_iss_seq
    import pci_iss_pkg::*;
#(
    parameter int WAIT_STATES = 1,
    parameter int ABORT_CLKS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              special,
    input  logic              is_wr,
    input  logic [CBE_W-1:0]  cmd,
    input  logic [AD_W-1:0]   addr_ad,
    input  logic [AD_W-1:0]   wdata,
    input  logic              devsel_n,
    input  logic              trdy_n,
    input  logic [AD_W-1:0]   ad_in,
    output logic              frame_n,
    output logic              irdy_n,
    output logic              ad_oe,
    output logic [AD_W-1:0]   ad_out,
    output logic [CBE_W-1:0]  cbe_n,
    output logic              busy,
    output logic              fin,
    output logic              fin_abort,
    output logic              fin_special,
    output logic [AD_W-1:0]   rd_data
);

    localparam int CNT_TOP = (ABORT_CLKS > WAIT_STATES) ? ABORT_CLKS : WAIT_STATES;
    localparam int CNT_W   = $clog2(CNT_TOP + 2);

    bus_st_e            st_q, st_d;
    logic [CNT_W-1:0]   cnt_q;
    logic               seen_q;
    logic               spec_q;
    logic               wr_q;
    logic               abort_q;
    logic [CBE_W-1:0]   cmd_q;
    logic [AD_W-1:0]    addr_q;
    logic [AD_W-1:0]    data_q;
    logic [AD_W-1:0]    rd_q;
    logic               hit;
    logic               claim_done;
    logic               timeout;
    logic               on_bus;

    assign on_bus     = (st_q == ST_ADDR) || (st_q == ST_WAIT) || (st_q == ST_DATA);
    assign hit        = !spec_q && (seen_q || !devsel_n);
    assign claim_done = (st_q == ST_DATA) && hit && !trdy_n;
    assign timeout    = (st_q == ST_DATA) && !hit && (cnt_q >= CNT_W'(ABORT_CLKS));

    // Next-state selection for the transaction sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_ADDR;
            ST_ADDR: st_d = (WAIT_STATES == 0) ? ST_DATA : ST_WAIT;
            ST_WAIT: if (cnt_q >= CNT_W'(WAIT_STATES)) st_d = ST_DATA;
            ST_DATA: if (claim_done || timeout) st_d = ST_REL;
            ST_REL:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register, clock counter and DEVSEL memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE) begin
                cnt_q  <= '0;
                seen_q <= 1'b0;
            end else begin
                if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                if (on_bus && !devsel_n) seen_q <= 1'b1;
            end
        end
    end

    // Latch the transaction description at start and the result at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q  <= 1'b0;
            wr_q    <= 1'b0;
            abort_q <= 1'b0;
            cmd_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            rd_q    <= '0;
        end else begin
            if (st_q == ST_IDLE && start) begin
                spec_q  <= special;
                wr_q    <= is_wr;
                cmd_q   <= cmd;
                addr_q  <= addr_ad;
                data_q  <= wdata;
                abort_q <= 1'b0;
            end
            if (timeout) abort_q <= 1'b1;
            if (claim_done) rd_q <= wr_q ? '0 : ad_in;
        end
    end

    // Bus pin values derived from the current state.
    always_comb begin
        frame_n = !on_bus;
        irdy_n  = !((st_q == ST_DATA) || (st_q == ST_REL));
        ad_oe   = (st_q == ST_ADDR) || (wr_q && (st_q != ST_IDLE));
        ad_out  = (st_q == ST_ADDR) ? addr_q : data_q;
        if (st_q == ST_IDLE)      cbe_n = 4'hF;
        else if (st_q == ST_ADDR) cbe_n = cmd_q;
        else                      cbe_n = 4'h0;
    end

    assign busy        = (st_q != ST_IDLE);
    assign fin         = (st_q == ST_REL);
    assign fin_abort   = abort_q;
    assign fin_special = spec_q;
    assign rd_data     = rd_q;

endmodule

// File: rtl/pci_iss_par.sv
// Module: pci_iss_par
// Registers even parity over AD and C/BE so PAR lags its phase by one clock.
// Assumes AD and C/BE are stable for the whole clock they are sampled in.
module pci_iss_par
    import pci_iss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AD_W-1:0]   ad,
    input  logic [CBE_W-1:0]  cbe_n,
    input  logic              ad_oe,
    output logic              par,
    output logic              par_oe
);

    // Parity bit and its enable, one clock behind the sourced phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par    <= 1'b0;
            par_oe <= 1'b0;
        end else begin
            par    <= ^{ad, cbe_n};
            par_oe <= ad_oe;
        end
    end

endmodule

// File: rtl/pci_cfg_issuer.sv
// Module: pci_cfg_issuer (top)
// Processor-side selector and status registers, access acceptance, and the
// completion response. Bus-side sequencing and parity live in submodules.
// Assumes one outstanding access; requests arriving while busy are dropped.
module pci_cfg_issuer
    import pci_iss_pkg::*;
#(
    parameter int WAIT_STATES = 1,
    parameter int ABORT_CLKS  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_ofs,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_busy,
    output logic        cpu_done,
    output logic [31:0] cpu_rdata,
    output logic [31:0] pci_ad_out,
    output logic        pci_ad_oe,
    input  logic [31:0] pci_ad_in,
    output logic [3:0]  pci_cbe_n,
    output logic        pci_frame_n,
    output logic        pci_irdy_n,
    input  logic        pci_devsel_n,
    input  logic        pci_trdy_n,
    output logic        pci_par,
    output logic        pci_par_oe
);

    localparam logic [AD_W-1:0] SEL_MASK = 32'h80FF_FFFC;

    logic [AD_W-1:0]  cfg_q;
    logic             sts_q;
    logic             done_q;
    logic [AD_W-1:0]  rdata_q;
    sel_t             sel;
    logic             accept;
    logic             dec_go;
    logic             dec_special;
    logic             dec_wr;
    logic [CBE_W-1:0] dec_cmd;
    logic [AD_W-1:0]  dec_ad;
    logic             seq_busy;
    logic             seq_fin;
    logic             seq_fin_abort;
    logic             seq_fin_special;
    logic [AD_W-1:0]  seq_rd;

    assign sel    = '{en: cfg_q[31], bus: cfg_q[23:16], dev: cfg_q[15:11],
                      fn: cfg_q[10:8], rg: cfg_q[7:2]};
    assign accept = cpu_req && !seq_busy;

    pci_iss_decode u_dec (
        .sel     (sel),
        .ofs     (cpu_ofs),
        .we      (cpu_we),
        .go      (dec_go),
        .special (dec_special),
        .is_wr   (dec_wr),
        .cmd     (dec_cmd),
        .addr_ad (dec_ad)
    );

    pci_iss_seq #(
        .WAIT_STATES (WAIT_STATES),
        .ABORT_CLKS  (ABORT_CLKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept && dec_go),
        .special     (dec_special),
        .is_wr       (dec_wr),
        .cmd         (dec_cmd),
        .addr_ad     (dec_ad),
        .wdata       (cpu_wdata),
        .devsel_n    (pci_devsel_n),
        .trdy_n      (pci_trdy_n),
        .ad_in       (pci_ad_in),
        .frame_n     (pci_frame_n),
        .irdy_n      (pci_irdy_n),
        .ad_oe       (pci_ad_oe),
        .ad_out      (pci_ad_out),
        .cbe_n       (pci_cbe_n),
        .busy        (seq_busy),
        .fin         (seq_fin),
        .fin_abort   (seq_fin_abort),
        .fin_special (seq_fin_special),
        .rd_data     (seq_rd)
    );

    pci_iss_par u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .ad     (pci_ad_out),
        .cbe_n  (pci_cbe_n),
        .ad_oe  (pci_ad_oe),
        .par    (pci_par),
        .par_oe (pci_par_oe)
    );

    // Selector register: written only through an accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (accept && cpu_we && cpu_ofs == OFS_SEL) begin
            cfg_q <= cpu_wdata & SEL_MASK;
        end
    end

    // Received-master-abort flag: set by non-special aborts, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (seq_fin && seq_fin_abort && !seq_fin_special) begin
            sts_q <= 1'b1;
        end else if (accept && cpu_we && cpu_ofs == OFS_STAT && cpu_wdata[0]) begin
            sts_q <= 1'b0;
        end
    end

    // Completion pulse and read data for register accesses and bus cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= seq_fin || (accept && !dec_go);
            if (seq_fin) begin
                rdata_q <= seq_fin_abort ? '1 : seq_rd;
            end else if (accept && !dec_go) begin
                unique case (cpu_ofs)
                    OFS_SEL:  rdata_q <= cfg_q;
                    OFS_DATA: rdata_q <= '1;
                    OFS_IACK: rdata_q <= '0;
                    default:  rdata_q <= {31'b0, sts_q};
                endcase
            end
        end
    end

    assign cpu_busy  = seq_busy;
    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/pci_iss_chk.sv
// Module: pci_iss_chk
// Temporal properties of the initiator, bound onto the top module.
// Assumes the default single-phase protocol with at least one wait state.
module pci_iss_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic [1:0]  cpu_ofs,
    input logic        cpu_busy,
    input logic        pci_frame_n,
    input logic        pci_irdy_n,
    input logic [3:0]  pci_cbe_n,
    input logic [31:0] pci_ad_out,
    input logic        pci_ad_oe,
    input logic        pci_par,
    input logic        pci_par_oe,
    input logic [31:0] cfg_q,
    input logic        sts_q,
    input logic        seq_fin,
    input logic        seq_fin_special
);

    p_special_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pci_frame_n) && pci_cbe_n == 4'b0001) |-> (pci_ad_oe && pci_ad_out == 32'h0));

    p_frame_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_frame_n) |-> !pci_irdy_n);

    p_irdy_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_frame_n) |=> pci_irdy_n);

    p_quiet_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fin && seq_fin_special) |=> $stable(sts_q));

    p_iack_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_busy && cpu_we && cpu_ofs == 2'd2) |=> (pci_frame_n && !cpu_busy));

    p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pci_par_oe |-> (pci_par == ^{$past(pci_ad_out), $past(pci_cbe_n)}));

    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_busy |=> $stable(cfg_q));

    p_no_self_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pci_frame_n) |-> $past(cpu_req && !cpu_busy));

endmodule

bind pci_cfg_issuer pci_iss_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_req         (cpu_req),
    .cpu_we          (cpu_we),
    .cpu_ofs         (cpu_ofs),
    .cpu_busy        (cpu_busy),
    .pci_frame_n     (pci_frame_n),
    .pci_irdy_n      (pci_irdy_n),
    .pci_cbe_n       (pci_cbe_n),
    .pci_ad_out      (pci_ad_out),
    .pci_ad_oe       (pci_ad_oe),
    .pci_par         (pci_par),
    .pci_par_oe      (pci_par_oe),
    .cfg_q           (cfg_q),
    .sts_q           (sts_q),
    .seq_fin         (seq_fin),
    .seq_fin_special (seq_fin_special)
);

// File: tb/pci_cfg_issuer_tb.sv
module pci_cfg_issuer_tb;

    localparam int W = 1;
    localparam int A = 5;
    localparam int NONE = 99;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_ofs = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_busy, cpu_done;
    logic [31:0] cpu_rdata;
    logic [31:0] pci_ad_out;
    logic        pci_ad_oe;
    logic [31:0] pci_ad_in = '0;
    logic [3:0]  pci_cbe_n;
    logic        pci_frame_n, pci_irdy_n;
    logic        pci_devsel_n = 1'b1;
    logic        pci_trdy_n = 1'b1;
    logic        pci_par, pci_par_oe;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    pci_cfg_issuer #(.WAIT_STATES(W), .ABORT_CLKS(A)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_ofs(cpu_ofs), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .pci_ad_out(pci_ad_out),
        .pci_ad_oe(pci_ad_oe), .pci_ad_in(pci_ad_in), .pci_cbe_n(pci_cbe_n),
        .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n),
        .pci_devsel_n(pci_devsel_n), .pci_trdy_n(pci_trdy_n),
        .pci_par(pci_par), .pci_par_oe(pci_par_oe)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=<200000", cycles);
                summary();
            end
        end
    end

    // Issue one access from a negedge; return at the negedge after the accept edge.
    task automatic cpu_op(input logic [1:0] ofs, input logic we, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_ofs = ofs; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] ofs, output logic [31:0] d);
        cpu_op(ofs, 1'b0, 32'h0);
        d = cpu_rdata;
    endtask

    // Follow one bus cycle from cycle k0, acting as target; parity checked every clock (R8).
    task automatic bus_watch(input int k0, input int dv_at, input int tr_at,
                             output int rel_k, output int irdy_k,
                             output logic [31:0] a_ad, output logic [3:0] a_cbe,
                             output logic [31:0] d_ad, output logic [3:0] d_cbe,
                             output int frame_clks);
        int k = k0;
        logic [31:0] p_ad = '0;
        logic [3:0]  p_cbe = '0;
        logic        p_oe = 1'b0;
        rel_k = -1; irdy_k = -1; frame_clks = 0;
        a_ad = '0; a_cbe = '0; d_ad = '0; d_cbe = '0;
        for (int guard = 0; guard < 60; guard++) begin
            pci_devsel_n = !(k >= dv_at);
            pci_trdy_n   = !(k >= tr_at);
            if (k == 0) begin a_ad = pci_ad_out; a_cbe = pci_cbe_n; end
            if (!pci_frame_n) frame_clks++;
            if (!pci_irdy_n && irdy_k < 0) begin irdy_k = k; d_ad = pci_ad_out; d_cbe = pci_cbe_n; end
            if (pci_frame_n && !pci_irdy_n) rel_k = k;
            if (k > k0) begin
                chk("R8 par_oe", {31'b0, pci_par_oe}, {31'b0, p_oe});
                if (p_oe) chk("R8 par", {31'b0, pci_par}, {31'b0, ^{p_ad, p_cbe}});
            end
            if (pci_frame_n && pci_irdy_n && k > 0) break;
            p_ad = pci_ad_out; p_cbe = pci_cbe_n; p_oe = pci_ad_oe;
            @(negedge clk);
            k++;
        end
        pci_devsel_n = 1'b1;
        pci_trdy_n = 1'b1;
    endtask

    function automatic logic [31:0] sel_word(input logic en, input logic [7:0] b,
                                             input logic [4:0] d, input logic [2:0] f,
                                             input logic [5:0] r);
        return {en, 7'b0, b, d, f, r, 2'b00};
    endfunction

    initial begin
        logic [31:0] rd, a_ad, d_ad, exp_ad, wd;
        logic [3:0]  a_cbe, d_cbe;
        int rel_k, irdy_k, fc;
        logic [7:0] buses [4] = '{8'h00, 8'h01, 8'h80, 8'hFF};
        logic [5:0] regs [3] = '{6'h00, 6'h01, 6'h3F};
        logic [15:0] msgs [5] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'hFFFF};
        bit spec;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset frame", {31'b0, pci_frame_n}, 32'h1);
        chk("R12 reset irdy", {31'b0, pci_irdy_n}, 32'h1);
        chk("R9 reset busy", {31'b0, cpu_busy}, 32'h0);
        chk("R8 reset par_oe", {31'b0, pci_par_oe}, 32'h0);
        chk("R11 reset done", {31'b0, cpu_done}, 32'h0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R12 idle frame", {31'b0, pci_frame_n}, 32'h1);
        end

        // Sweep of selector decode with writes and no target (R1 R2 R3 R4 R5 R6).
        for (int bi = 0; bi < 4; bi++)
            for (int dv = 0; dv < 32; dv++)
                for (int fi = 0; fi < 2; fi++)
                    for (int ri = 0; ri < 3; ri++) begin
                        logic [2:0] fn = (fi == 0) ? 3'd0 : 3'd7;
                        cpu_op(2'd0, 1'b1, sel_word(1'b1, buses[bi], 5'(dv), fn, regs[ri]));
                        wd = 32'hA500_0000 ^ (32'(buses[bi]) << 16) ^ (32'(dv) << 4) ^ 32'(regs[ri]);
                        cpu_op(2'd1, 1'b1, wd);
                        bus_watch(0, NONE, NONE, rel_k, irdy_k, a_ad, a_cbe, d_ad, d_cbe, fc);
                        spec = (buses[bi] == 8'h00) && (dv == 31) && (fn == 3'd7) && (regs[ri] == 6'h00);
                        if (spec) begin
                            chk("R1 cmd", {28'b0, a_cbe}, 32'h1);
                            chk("R1 addr", a_ad, 32'h0);
                        end else if (buses[bi] != 8'h00) begin
                            exp_ad = (32'(buses[bi]) << 16) | (32'(dv) << 11) | (32'(fn) << 8)
                                   | (32'(regs[ri]) << 2) | 32'h1;
                            chk("R2 cmd", {28'b0, a_cbe}, 32'hB);
                            chk("R2 addr", a_ad, exp_ad);
                        end else begin
                            exp_ad = (32'(fn) << 8) | (32'(regs[ri]) << 2);
                            if (dv < 21) exp_ad = exp_ad | (32'h1 << (11 + dv));
                            chk("R3 cmd", {28'b0, a_cbe}, 32'hB);
                            chk("R3 addr", a_ad, exp_ad);
                        end
                        chk("R4 irdy clock", 32'(irdy_k), 32'(W + 1));
                        chk("R4 data", d_ad, wd);
                        chk("R4 cbe", {28'b0, d_cbe}, 32'h0);
                        chk("R5 release clock", 32'(rel_k), 32'(A + 1));
                        chk("R5 frame length", 32'(fc), 32'(A + 1));
                        chk("R6 done", {31'b0, cpu_done}, 32'h1);
                        reg_rd(2'd3, rd);
                        chk("R6 status", rd, spec ? 32'h0 : 32'h1);
                        if (!spec) cpu_op(2'd3, 1'b1, 32'h1);
                    end

        // Special cycles with message codes; target responses ignored (R4 R5 R6).
        cpu_op(2'd0, 1'b1, sel_word(1'b1, 8'h00, 5'h1F, 3'h7, 6'h00));
        for (int m = 0; m < 5; m++) begin
            wd = {16'h5A00 + 16'(m), msgs[m]};
            cpu_op(2'd1, 1'b1, wd);
            bus_watch(0, 1, 2, rel_k, irdy_k, a_ad, a_cbe, d_ad, d_cbe, fc);
            chk("R1 special cmd", {28'b0, a_cbe}, 32'h1);
            chk("R4 message", d_ad, wd);
            chk("R5 ignores target", 32'(rel_k), 32'(A + 1));
            reg_rd(2'd3, rd);
            chk("R6 special leaves status", rd, 32'h0);
        end

        // Claimed type 0 read (R11).
        cpu_op(2'd0, 1'b1, sel_word(1'b1, 8'h00, 5'd3, 3'd1, 6'h04));
        pci_ad_in = 32'h1234_5678;
        cpu_op(2'd1, 1'b0, 32'h0);
        bus_watch(0, 1, 3, rel_k, irdy_k, a_ad, a_cbe, d_ad, d_cbe, fc);
        chk("R11 cmd", {28'b0, a_cbe}, 32'hA);
        chk("R11 release", 32'(rel_k), 32'd4);
        chk("R11 done", {31'b0, cpu_done}, 32'h1);
        chk("R11 rdata", cpu_rdata, 32'h1234_5678);
        reg_rd(2'd3, rd);
        chk("R11 status", rd, 32'h0);

        // DEVSEL on exactly the timeout clock, then one clock late (R6).
        pci_ad_in = 32'hCAFE_0001;
        cpu_op(2'd1, 1'b0, 32'h0);
        bus_watch(0, A, A, rel_k, irdy_k, a_ad, a_cbe, d_ad, d_cbe, fc);
        chk("R6 claim on timeout clock", cpu_rdata, 32'hCAFE_0001);
        chk("R6 release same", 32'(rel_k), 32'(A + 1));
        reg_rd(2'd3, rd);
        chk("R6 claim keeps status", rd, 32'h0);
        cpu_op(2'd1, 1'b0, 32'h0);
        bus_watch(0, A + 1, A + 1, rel_k, irdy_k, a_ad, a_cbe, d_ad, d_cbe, fc);
        chk("R6 late claim aborts", cpu_rdata, 32'hFFFF_FFFF);
        chk("R6 late release", 32'(rel_k), 32'(A + 1));
        reg_rd(2'd3, rd);
        chk("R6 abort sets status", rd, 32'h1);
        cpu_op(2'd3, 1'b1, 32'h1);
        reg_rd(2'd3, rd);
        chk("R6 write-one clears", rd, 32'h0);

        // Interrupt acknowledge read and ignored write (R7).
        pci_ad_in = 32'h0000_0042;
        cpu_op(2'd2, 1'b0, 32'h0);
        bus_watch(0, 1, 2, rel_k, irdy_k, a_ad, a_cbe, d_ad, d_cbe, fc);
        chk("R7 iack cmd", {28'b0, a_cbe}, 32'h0);
        chk("R7 iack addr", a_ad, 32'h0);
        chk("R7 iack vector", cpu_rdata, 32'h0000_0042);
        cpu_op(2'd2, 1'b1, 32'hFFFF_FFFF);
        chk("R7 write done", {31'b0, cpu_done}, 32'h1);
        for (int i = 0; i < 6; i++) begin
            chk("R7 write no frame", {31'b0, pci_frame_n}, 32'h1);
            chk("R7 write not busy", {31'b0, cpu_busy}, 32'h0);
            @(negedge clk);
        end

        // Selector write while busy is dropped (R9).
        cpu_op(2'd0, 1'b1, sel_word(1'b1, 8'h00, 5'h1F, 3'h7, 6'h00));
        cpu_op(2'd1, 1'b1, 32'h0000_0001);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_ofs = 2'd0; cpu_wdata = 32'h8012_3400;
        @(negedge clk);
        cpu_req = 1'b0;
        bus_watch(1, NONE, NONE, rel_k, irdy_k, a_ad, a_cbe, d_ad, d_cbe, fc);
        reg_rd(2'd0, rd);
        chk("R9 selector held", rd, sel_word(1'b1, 8'h00, 5'h1F, 3'h7, 6'h00));

        // Enable clear: no bus cycle, read all ones (R10).
        cpu_op(2'd0, 1'b1, sel_word(1'b0, 8'h00, 5'd2, 3'd0, 6'h00));
        cpu_op(2'd1, 1'b1, 32'h1111_2222);
        chk("R10 write done", {31'b0, cpu_done}, 32'h1);
        chk("R10 no frame", {31'b0, pci_frame_n}, 32'h1);
        @(negedge clk);
        chk("R10 still idle", {31'b0, pci_frame_n}, 32'h1);
        reg_rd(2'd1, rd);
        chk("R10 read all ones", rd, 32'hFFFF_FFFF);
        chk("R10 read no frame", {31'b0, pci_frame_n}, 32'h1);

        summary();
    end

endmodule